// File: doc/BRIEF.md
# Calendar Event and Interrupt Unit

This block sits beside a running time-of-day and calendar counter and turns its per-second tick into sticky event flags. On each tick it looks at the new time and date values and decides whether a second, a selected time boundary or a selected calendar boundary has just been crossed. Two more flags latch pulses from the counter: an alarm match and an update acknowledge. The counter itself is outside this block.

Software uses a small strobe-based register file. It picks the time and calendar boundaries, clears flags one by one, and sets or clears bits of an interrupt mask through two separate write-only ports. One registered interrupt line is the OR of every flag that is also enabled in the mask. A keyed protect register can lock the control register against stray writes.

All time and date inputs are plain binary. Weekday 1 is Monday. Hours run from 0 to 23. The inputs show the new time in the cycle where `tick` is high.

Top module: `cal_evt_unit`

## Requirements
- R1: After a synchronous reset, all flags, the mask, both selections and the protect bit are zero, and `irq` and `rdata` are low.
- R2: Every cycle with `tick` high sets status bit 2 (second event).
- R3: The time selection sits in control bits 9:8. A tick sets status bit 3 when the new time meets the selected condition. For 0 the condition is second 0. For 1 it is minute 0 and second 0. For 2 it is 00:00:00. For 3 it is 12:00:00.
- R4: The calendar selection sits in control bits 17:16. A tick at 00:00:00 sets status bit 4 when the selected condition also holds. For 0 the condition is weekday 1 (Monday). For 1 it is date 1. For 2 it is date 1 in month 1. Value 3 never fires.
- R5: A high `alarm_hit` sets status bit 1, and a high `upd_ack` sets status bit 0.
- R6: A status bit stays set until a write to the clear port (address 2) has a 1 in that bit position. Zero bits of that write leave their flags unchanged.
- R7: When an event and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: A write to address 3 sets the mask bits written as 1. A write to address 4 clears the mask bits written as 1. Zero bits have no effect. The mask reads back at address 5.
- R9: `irq` is high exactly when some status bit and its mask bit are both set. It follows the flags and mask in the same cycle they update.
- R10: A write to the protect register (address 6) takes effect only when bits 31:8 hold 0x525443. The register then loads the protect bit from bit 0. Reads return only bit 0, and the key field always reads zero.
- R11: While the protect bit is set, writes to the control register (address 0) are ignored.
- R12: A read with `rd_en` high returns the addressed value on `rdata` in the next cycle. The address map is: 0 control, 1 status, 5 mask, 6 protect. Addresses 2, 3, 4 and 7 read zero. In a cycle after no read, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse once per second; time and date inputs hold the new values |
| sec | input | 6 | Current second, binary |
| min | input | 6 | Current minute, binary |
| hour | input | 5 | Current hour 0..23, binary |
| wday | input | 3 | Day of week, 1 = Monday |
| date | input | 5 | Day of month, from 1 |
| month | input | 4 | Month, 1 = January |
| alarm_hit | input | 1 | Alarm match pulse from the counter |
| upd_ack | input | 1 | Update-acknowledge pulse from the counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The clear port and the event logic can both act on the same flag in one cycle. The bench provokes this by issuing a clear write together with a tick that lands on a boundary. It then reads the status register and expects the flag to still be set. A second same-cycle case pairs a status read with a flag update. The read must return the value from before the edge, and the next read must show the new flag. A behavioural model steps on every clock and checks `irq` and `rdata` in each cycle.

// File: rtl/cal_evt_pkg.sv
package cal_evt_pkg;
  typedef enum logic [1:0] {TEV_MINUTE, TEV_HOUR, TEV_MIDNIGHT, TEV_NOON} tev_sel_e;
  typedef enum logic [1:0] {CEV_WEEK, CEV_MONTH, CEV_YEAR, CEV_OFF} cev_sel_e;

  localparam int FLAG_N  = 5;
  localparam int FL_ACK  = 0;
  localparam int FL_ALM  = 1;
  localparam int FL_SEC  = 2;
  localparam int FL_TIM  = 3;
  localparam int FL_CAL  = 4;

  localparam int A_CTRL  = 0;
  localparam int A_STAT  = 1;
  localparam int A_CLR   = 2;
  localparam int A_MSET  = 3;
  localparam int A_MCLR  = 4;
  localparam int A_MASK  = 5;
  localparam int A_PROT  = 6;

  localparam int TSEL_LSB = 8;
  localparam int CSEL_LSB = 16;
  localparam int KEY_LSB  = 8;
  localparam logic [23:0] PROT_KEY = 24'h525443;
endpackage

// File: rtl/cal_evt_detect.sv
module cal_evt_detect
  import cal_evt_pkg::*;
#(
  parameter int SEC_W     = 6,
  parameter int MIN_W     = 6,
  parameter int HOUR_W    = 5,
  parameter int WDAY_W    = 3,
  parameter int DATE_W    = 5,
  parameter int MON_W     = 4,
  parameter int MONDAY    = 1,
  parameter int NOON_HOUR = 12
) (
  input  logic              tick,
  input  logic [SEC_W-1:0]  sec,
  input  logic [MIN_W-1:0]  min,
  input  logic [HOUR_W-1:0] hour,
  input  logic [WDAY_W-1:0] wday,
  input  logic [DATE_W-1:0] date,
  input  logic [MON_W-1:0]  month,
  input  tev_sel_e          tsel,
  input  cev_sel_e          csel,
  output logic              sec_ev,
  output logic              tim_ev,
  output logic              cal_ev
);
  logic top_min, top_hour, midnight, noon, first_day;

  assign top_min   = (sec == '0);
  assign top_hour  = top_min && (min == '0);
  assign midnight  = top_hour && (hour == '0);
  assign noon      = top_hour && (hour == HOUR_W'(NOON_HOUR));
  assign first_day = (date == DATE_W'(1));
  assign sec_ev    = tick;

  always_comb begin
    case (tsel)
      TEV_MINUTE:   tim_ev = tick && top_min;
      TEV_HOUR:     tim_ev = tick && top_hour;
      TEV_MIDNIGHT: tim_ev = tick && midnight;
      TEV_NOON:     tim_ev = tick && noon;
      default:      tim_ev = 1'b0;
    endcase
  end

  always_comb begin
    case (csel)
      CEV_WEEK:  cal_ev = tick && midnight && (wday == WDAY_W'(MONDAY));
      CEV_MONTH: cal_ev = tick && midnight && first_day;
      CEV_YEAR:  cal_ev = tick && midnight && first_day && (month == MON_W'(1));
      default:   cal_ev = 1'b0;
    endcase
  end
endmodule

// File: rtl/cal_evt_flags.sv
module cal_evt_flags #(
  parameter int N = cal_evt_pkg::FLAG_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mset,
  input  logic [N-1:0] mclr,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] mask_q,
  output logic         irq_q
);
  logic [N-1:0] flags_d, mask_d;

  // events are ORed after the clear so a coincident event survives
  assign flags_d = (flags_q & ~clr) | ev;
  assign mask_d  = (mask_q | mset) & ~mclr;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
      irq_q   <= |(flags_d & mask_d);
    end
  end

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((flags_q & $past(ev)) == $past(ev)));

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((mset & ~mclr) != '0) |=> ((mask_q & $past(mset & ~mclr)) == $past(mset & ~mclr)));
endmodule

// File: rtl/cal_evt_regs.sv
module cal_evt_regs
  import cal_evt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int N      = FLAG_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      flags,
  input  logic [N-1:0]      mask,
  output tev_sel_e          tsel_q,
  output cev_sel_e          csel_q,
  output logic [N-1:0]      clr,
  output logic [N-1:0]      mset,
  output logic [N-1:0]      mclr,
  output logic [DATA_W-1:0] rdata
);
  localparam int KEY_W = DATA_W - KEY_LSB;

  logic              prot_q;
  logic              key_ok;
  logic [DATA_W-1:0] rd_val;
  logic              unused_wdata;

  assign key_ok       = (wdata[DATA_W-1:KEY_LSB] == KEY_W'(PROT_KEY));
  assign unused_wdata = ^wdata;

  assign clr  = (wr_en && addr == ADDR_W'(A_CLR))  ? wdata[N-1:0] : '0;
  assign mset = (wr_en && addr == ADDR_W'(A_MSET)) ? wdata[N-1:0] : '0;
  assign mclr = (wr_en && addr == ADDR_W'(A_MCLR)) ? wdata[N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tsel_q <= TEV_MINUTE;
      csel_q <= CEV_WEEK;
      prot_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_CTRL) && !prot_q) begin
        tsel_q <= tev_sel_e'(wdata[TSEL_LSB +: 2]);
        csel_q <= cev_sel_e'(wdata[CSEL_LSB +: 2]);
      end
      if (addr == ADDR_W'(A_PROT) && key_ok)
        prot_q <= wdata[0];
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      ADDR_W'(A_CTRL): begin
        rd_val[TSEL_LSB +: 2] = tsel_q;
        rd_val[CSEL_LSB +: 2] = csel_q;
      end
      ADDR_W'(A_STAT): rd_val[N-1:0] = flags;
      ADDR_W'(A_MASK): rd_val[N-1:0] = mask;
      ADDR_W'(A_PROT): rd_val[0]     = prot_q;
      default:         rd_val        = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
    else            rdata <= '0;
  end

  // R11
  prot_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_q && wr_en && addr == ADDR_W'(A_CTRL)) |=> ($stable(tsel_q) && $stable(csel_q)));

  // R12
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));

  // R10
  prot_key_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_PROT) && !key_ok) |=> $stable(prot_q));
endmodule

// File: rtl/cal_evt_unit.sv
module cal_evt_unit
  import cal_evt_pkg::*;
#(
  parameter int SEC_W  = 6,
  parameter int MIN_W  = 6,
  parameter int HOUR_W = 5,
  parameter int WDAY_W = 3,
  parameter int DATE_W = 5,
  parameter int MON_W  = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [SEC_W-1:0]  sec,
  input  logic [MIN_W-1:0]  min,
  input  logic [HOUR_W-1:0] hour,
  input  logic [WDAY_W-1:0] wday,
  input  logic [DATE_W-1:0] date,
  input  logic [MON_W-1:0]  month,
  input  logic              alarm_hit,
  input  logic              upd_ack,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  tev_sel_e          tsel;
  cev_sel_e          csel;
  logic              sec_ev, tim_ev, cal_ev;
  logic [FLAG_N-1:0] ev, clr, mset, mclr, flags, mask;

  always_comb begin
    ev         = '0;
    ev[FL_ACK] = upd_ack;
    ev[FL_ALM] = alarm_hit;
    ev[FL_SEC] = sec_ev;
    ev[FL_TIM] = tim_ev;
    ev[FL_CAL] = cal_ev;
  end

  cal_evt_detect #(
    .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
    .WDAY_W(WDAY_W), .DATE_W(DATE_W), .MON_W(MON_W),
    .MONDAY(1), .NOON_HOUR(12)
  ) u_detect (
    .tick(tick), .sec(sec), .min(min), .hour(hour), .wday(wday),
    .date(date), .month(month), .tsel(tsel), .csel(csel),
    .sec_ev(sec_ev), .tim_ev(tim_ev), .cal_ev(cal_ev)
  );

  cal_evt_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .ev(ev), .clr(clr), .mset(mset), .mclr(mclr),
    .flags_q(flags), .mask_q(mask), .irq_q(irq)
  );

  cal_evt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(FLAG_N)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flags(flags), .mask(mask), .tsel_q(tsel), .csel_q(csel),
    .clr(clr), .mset(mset), .mclr(mclr), .rdata(rdata)
  );

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & mask));

  // R2
  sec_flag_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> flags[FL_SEC]);
endmodule

// File: tb/sim_cal_evt_unit.sv
`timescale 1ns/1ps
module sim_cal_evt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [5:0]  sec = '0;
  logic [5:0]  min = '0;
  logic [4:0]  hour = '0;
  logic [2:0]  wday = 3'd1;
  logic [4:0]  date = 5'd1;
  logic [3:0]  month = 4'd1;
  logic        alarm_hit = 1'b0;
  logic        upd_ack = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_flags = 0, m_mask = 0, m_tsel = 0, m_csel = 0, m_prot = 0;
  int exp_rdata = 0;
  bit exp_irq = 0;

  always #2.5 clk = ~clk;

  cal_evt_unit u0 (
    .clk(clk), .rst(rst), .tick(tick), .sec(sec), .min(min), .hour(hour),
    .wday(wday), .date(date), .month(month), .alarm_hit(alarm_hit),
    .upd_ack(upd_ack), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated at the rising edge on the driven inputs
  task automatic model();
    int ev = 0, clr = 0, st = 0, sc = 0, top = 0;
    if (rst) begin
      m_flags = 0; m_mask = 0; m_tsel = 0; m_csel = 0; m_prot = 0;
      exp_rdata = 0; exp_irq = 0;
      return;
    end
    if (rd_en) begin
      case (addr)
        3'd0: exp_rdata = (m_tsel << 8) | (m_csel << 16);
        3'd1: exp_rdata = m_flags;
        3'd5: exp_rdata = m_mask;
        3'd6: exp_rdata = m_prot;
        default: exp_rdata = 0;
      endcase
    end else exp_rdata = 0;
    top = (sec == 0 && min == 0 && hour == 0);
    if (tick) begin
      ev |= 4;
      if (sec == 0 && (m_tsel == 0 || (min == 0 && (m_tsel == 1 ||
          (m_tsel == 2 && hour == 0) || (m_tsel == 3 && hour == 12)))))
        ev |= 8;
      if (top && ((m_csel == 0 && wday == 1) || (m_csel == 1 && date == 1) ||
          (m_csel == 2 && date == 1 && month == 1)))
        ev |= 16;
    end
    if (alarm_hit) ev |= 2;
    if (upd_ack) ev |= 1;
    if (wr_en) begin
      case (addr)
        3'd0: if (m_prot == 0) begin m_tsel = int'(wdata[9:8]); m_csel = int'(wdata[17:16]); end
        3'd2: clr = int'(wdata[4:0]);
        3'd3: st = int'(wdata[4:0]);
        3'd4: sc = int'(wdata[4:0]);
        3'd6: if (wdata[31:8] == 24'h525443) m_prot = int'(wdata[0]);
        default: ;
      endcase
    end
    m_flags = ((m_flags & ~clr) | ev) & 31;
    m_mask  = ((m_mask | st) & ~sc) & 31;
    exp_irq = (m_flags & m_mask) != 0;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk("R9 irq", 32'(irq), 32'(exp_irq));
    chk("R12 rdata", rdata, exp_rdata);
    tick = 0; alarm_hit = 0; upd_ack = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    step();
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    rd_en = 1; addr = a;
    step();
    chk(tag, rdata, e);
  endtask

  task automatic tk(input int h, input int m, input int s, input int wd, input int dt, input int mo);
    tick = 1; hour = 5'(h); min = 6'(m); sec = 6'(s);
    wday = 3'(wd); date = 5'(dt); month = 4'(mo);
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst = 0;
    // R1 reset state
    chk("R1 irq", 32'(irq), 32'd0);
    rd_chk(3'd1, 32'h0, "R1 status");
    rd_chk(3'd5, 32'h0, "R1 mask");
    rd_chk(3'd0, 32'h0, "R1 ctrl");
    rd_chk(3'd6, 32'h0, "R1 prot");

    // R2 second event
    tk(10, 20, 30, 3, 5, 6);
    rd_chk(3'd1, 32'h04, "R2 second flag");

    // R6 clear with zeros in the target bit, then with a one
    wr(3'd2, 32'h1B);
    rd_chk(3'd1, 32'h04, "R6 zero bits keep flag");
    wr(3'd2, 32'h04);
    rd_chk(3'd1, 32'h00, "R6 flag cleared");

    // R3 minute change
    tk(10, 21, 0, 3, 5, 6);
    rd_chk(3'd1, 32'h0C, "R3 minute event");
    wr(3'd2, 32'h1F);
    tk(10, 21, 5, 3, 5, 6);
    rd_chk(3'd1, 32'h04, "R3 no minute event mid-minute");
    wr(3'd2, 32'h1F);
    // R3 hour change
    wr(3'd0, 32'h100);
    tk(10, 22, 0, 3, 5, 6);
    rd_chk(3'd1, 32'h04, "R3 hour sel ignores minute");
    tk(11, 0, 0, 3, 5, 6);
    rd_chk(3'd1, 32'h0C, "R3 hour event");
    wr(3'd2, 32'h1F);
    // R3 midnight
    wr(3'd0, 32'h200);
    tk(12, 0, 0, 3, 5, 6);
    rd_chk(3'd1, 32'h04, "R3 midnight sel ignores noon");
    tk(0, 0, 0, 3, 5, 6);
    rd_chk(3'd1, 32'h0C, "R3 midnight event");
    wr(3'd2, 32'h1F);
    // R3 noon
    wr(3'd0, 32'h300);
    tk(12, 0, 0, 3, 5, 6);
    rd_chk(3'd1, 32'h0C, "R3 noon event");
    wr(3'd2, 32'h1F);

    // R4 week change
    wr(3'd0, 32'h0);
    tk(0, 0, 0, 1, 9, 6);
    rd_chk(3'd1, 32'h1C, "R4 week event on Monday");
    wr(3'd2, 32'h1F);
    // R4 month change
    wr(3'd0, 32'h10000);
    tk(0, 0, 0, 1, 9, 6);
    rd_chk(3'd1, 32'h0C, "R4 month sel ignores Monday");
    tk(0, 0, 0, 4, 1, 6);
    rd_chk(3'd1, 32'h1C, "R4 month event");
    wr(3'd2, 32'h1F);
    tk(0, 0, 5, 4, 1, 6);
    rd_chk(3'd1, 32'h04, "R4 no month event off midnight");
    wr(3'd2, 32'h1F);
    // R4 year change
    wr(3'd0, 32'h20000);
    tk(0, 0, 0, 2, 1, 3);
    rd_chk(3'd1, 32'h0C, "R4 year sel ignores other months");
    tk(0, 0, 0, 2, 1, 1);
    rd_chk(3'd1, 32'h1C, "R4 year event");
    wr(3'd2, 32'h1F);
    // R4 value 3 never fires
    wr(3'd0, 32'h30000);
    tk(0, 0, 0, 1, 1, 1);
    rd_chk(3'd1, 32'h0C, "R4 sel 3 no event");
    wr(3'd2, 32'h1F);

    // R5 alarm and update acknowledge
    alarm_hit = 1;
    step();
    rd_chk(3'd1, 32'h02, "R5 alarm flag");
    upd_ack = 1;
    step();
    rd_chk(3'd1, 32'h03, "R5 ack flag");
    wr(3'd2, 32'h1F);

    // R7 event and clear in the same cycle
    tick = 1; hour = 5'd10; min = 6'd30; sec = 6'd15;
    wr_en = 1; addr = 3'd2; wdata = 32'h04;
    step();
    rd_chk(3'd1, 32'h04, "R7 event wins over clear");
    // read coinciding with a flag update returns the old value
    alarm_hit = 1; rd_en = 1; addr = 3'd1;
    step();
    chk("R12 read before update", rdata, 32'h04);
    rd_chk(3'd1, 32'h06, "R12 read after update");
    wr(3'd2, 32'h1F);

    // R8 mask set/clear
    wr(3'd3, 32'h06);
    rd_chk(3'd5, 32'h06, "R8 mask set");
    wr(3'd4, 32'h02);
    rd_chk(3'd5, 32'h04, "R8 mask clear");
    wr(3'd4, 32'h00);
    wr(3'd3, 32'h00);
    rd_chk(3'd5, 32'h04, "R8 zero writes no effect");

    // R9 irq behaviour
    chk("R9 irq low with no flags", 32'(irq), 32'd0);
    alarm_hit = 1;
    step();
    chk("R9 unmasked flag no irq", 32'(irq), 32'd0);
    tk(10, 31, 7, 3, 5, 6);
    chk("R9 masked flag irq", 32'(irq), 32'd1);
    wr(3'd4, 32'h04);
    chk("R9 mask cleared irq low", 32'(irq), 32'd0);
    wr(3'd3, 32'h04);
    chk("R9 mask set irq high", 32'(irq), 32'd1);
    wr(3'd2, 32'h04);
    chk("R9 flag cleared irq low", 32'(irq), 32'd0);
    wr(3'd2, 32'h1F);

    // R10 keyed protect
    wr(3'd6, 32'h0000_0001);
    rd_chk(3'd6, 32'h0, "R10 wrong key ignored");
    wr(3'd6, 32'h5254_4301);
    rd_chk(3'd6, 32'h1, "R10 key accepted, key reads zero");

    // R11 control locked
    wr(3'd0, 32'h100);
    rd_chk(3'd0, 32'h30000, "R11 ctrl unchanged");
    tk(10, 40, 0, 3, 5, 6);
    rd_chk(3'd1, 32'h0C, "R11 minute selection still active");
    wr(3'd2, 32'h1F);
    wr(3'd6, 32'h5254_4300);
    rd_chk(3'd6, 32'h0, "R10 protect released");
    wr(3'd0, 32'h100);
    rd_chk(3'd0, 32'h100, "R11 ctrl writable again");

    // R12 write-only and unused addresses read zero, idle rdata zero
    rd_chk(3'd3, 32'h0, "R12 mask-set port reads zero");
    rd_chk(3'd7, 32'h0, "R12 unused address reads zero");
    step();
    chk("R12 idle rdata", rdata, 32'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule